// File: doc/BRIEF.md
# Banked Memory Address Decoder

This block is the glue logic between an 8-bit processor with a 16-bit address bus and its memories. It holds two bank registers. Stores to the two lowest zero-page locations load them. Each access is then steered to one of four targets: flat low RAM, a one-page I/O window, a switched 8 KB high-RAM window, or a switched 16 KB ROM window. For the banked targets the block also supplies the upper physical address lines.

The bank registers cannot be read back. A store to either register location also completes into low RAM, so a later read of that location returns the RAM copy. The high-RAM bank number is split in two:

- Its low bits drive the upper address pins of every high-RAM device.
- Its top bits are decoded into one active-low select per device.

Decoding is purely combinational from the current address and the stored banks. A bank store therefore takes effect at the clock edge that ends it, and the access after it sees the new bank.

Top module: `bank_addr_decode`

## Requirements
- R1: After a synchronous active-low reset, both bank registers hold 0. An access to $A000 selects high-RAM device 0 with upper address 0, and an access to $C000 selects ROM bank 0.
- R2: Addresses $0000–$9EFF assert only `lram_cs_n`. `lram_we_n` is low exactly when such an access is a write.
- R3: Addresses $9F00–$9FFF assert only `io_cs_n`.
- R4: Addresses $A000–$BFFF assert exactly one bit of `hram_cs_n`, namely bit number RAM bank[7:6]. `hram_addr_hi` equals RAM bank[5:0].
- R5: Addresses $C000–$FFFF assert only `rom_cs_n`. `rom_addr_hi` equals the ROM bank register, which is 5 bits wide.
- R6: A write to $0000 loads `cpu_din[7:0]` into the RAM bank register. The new value applies from the next access. The same write also asserts `lram_we_n`.
- R7: A write to $0001 loads `cpu_din[4:0]` into the ROM bank register. The upper data bits are ignored. The new value applies from the next access, and the write also asserts `lram_we_n`.
- R8: In every cycle exactly one of the seven chip selects is low.
- R9: Reads of $0000 or $0001, and writes to any other address, leave both bank registers unchanged.
- R10: A write outside $0000–$9EFF never asserts `lram_we_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one CPU access per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wr | input | 1 | 1 = write access, 0 = read |
| cpu_din | input | 8 | CPU write data |
| hram_addr_hi | output | 6 | Upper address lines shared by the high-RAM devices |
| hram_cs_n | output | 4 | Active-low select, one per high-RAM device |
| rom_addr_hi | output | 5 | Upper ROM address lines (bank number) |
| rom_cs_n | output | 1 | Active-low ROM select |
| io_cs_n | output | 1 | Active-low I/O page select |
| lram_cs_n | output | 1 | Active-low flat low-RAM select |
| lram_we_n | output | 1 | Active-low low-RAM write enable |

## Verification
Three properties are checked by assertions on every cycle:

- exactly one select is active;
- a select is only active for an address inside its own region;
- a bank register follows a store to its location and holds steady otherwise.

Only the bench scenarios can show the full mapping against an arithmetic model:

- the device number taken from the top bank bits;
- the masking of the unused ROM data bits;
- the one-cycle delay before a new bank applies;
- the write-through of bank stores into low RAM.

The bench sweeps the address space under several bank settings and follows with mixed random traffic.

// File: rtl/bank_dec_pkg.sv
// Package: shared types and fixed locations for the banked address decoder.
// Assumes a 16-bit CPU address bus.
package bank_dec_pkg;

    // Target region chosen for one access
    typedef enum logic [1:0] {
        RGN_LOW  = 2'd0,
        RGN_IO   = 2'd1,
        RGN_HRAM = 2'd2,
        RGN_ROM  = 2'd3
    } region_e;

    localparam int unsigned CPU_AW = 16;

    // Store locations of the two bank registers
    localparam logic [CPU_AW-1:0] RAM_BANK_LOC = 16'h0000;
    localparam logic [CPU_AW-1:0] ROM_BANK_LOC = 16'h0001;

    // I/O page: A12..A8 all ones inside the $8000 quarter
    localparam logic [4:0] IO_PAGE_TAG = 5'b11111;

endpackage

// File: rtl/region_decode.sv
// Module: region_decode
// Maps a CPU address to one target region. A15=0 is always low RAM.
// With A15=1, A14:A13 picks a quarter: the $8000 quarter is low RAM except
// the I/O page, the $A000 quarter is high RAM, the two upper quarters are ROM.
// Assumes a 16-bit address; purely combinational.
module region_decode
    import bank_dec_pkg::*;
(
    input  logic [CPU_AW-1:0] addr,
    output region_e           region
);

    logic [1:0] quarter;
    logic       io_page_hit;

    // Split the upper half of the map into four 8 KB quarters
    always_comb begin
        quarter     = addr[14:13];
        io_page_hit = (addr[12:8] == IO_PAGE_TAG);
    end

    // Select the region from A15, the quarter and the I/O page tag
    always_comb begin
        if (!addr[15]) begin
            region = RGN_LOW;
        end else begin
            unique case (quarter)
                2'b00:   region = io_page_hit ? RGN_IO : RGN_LOW;
                2'b01:   region = RGN_HRAM;
                default: region = RGN_ROM;
            endcase
        end
    end

endmodule

// File: rtl/cs_decoder.sv
// Module: cs_decoder
// Generic N-to-2**N active-low select decoder with an enable.
// All outputs stay high when the enable is low.
module cs_decoder #(
    parameter int unsigned SEL_W = 2,
    localparam int unsigned OUT_N = 1 << SEL_W
) (
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic [OUT_N-1:0] cs_n
);

    // One comparator per output line
    for (genvar i = 0; i < OUT_N; i++) begin : g_line
        assign cs_n[i] = !(en && (sel == SEL_W'(i)));
    end

endmodule

// File: rtl/bank_regs.sv
// Module: bank_regs
// Holds the write-only RAM and ROM bank latches. A write access to the RAM
// bank location loads the full data byte. A write to the ROM bank location
// loads the low ROM_BANK_W data bits. Updates land on the clock edge that
// ends the write. Assumes one access per cycle and a synchronous active-low
// reset.
module bank_regs
    import bank_dec_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned RAM_BANK_W = 8,
    parameter int unsigned ROM_BANK_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CPU_AW-1:0]     addr,
    input  logic                  wr,
    input  logic [DATA_W-1:0]     din,
    output logic [RAM_BANK_W-1:0] ram_bank,
    output logic [ROM_BANK_W-1:0] rom_bank
);

    logic ram_ld;
    logic rom_ld;

    // Detect stores to each bank location
    always_comb begin
        ram_ld = wr && (addr == RAM_BANK_LOC);
        rom_ld = wr && (addr == ROM_BANK_LOC);
    end

    // RAM bank latch: clears on reset, loads on a store to its location
    always_ff @(posedge clk) begin
        if (!rst_n)      ram_bank <= '0;
        else if (ram_ld) ram_bank <= din[RAM_BANK_W-1:0];
    end

    // ROM bank latch: clears on reset, loads the low data bits on a store
    always_ff @(posedge clk) begin
        if (!rst_n)      rom_bank <= '0;
        else if (rom_ld) rom_bank <= din[ROM_BANK_W-1:0];
    end

    // R6: a RAM bank store is visible after the edge ending it
    p_ram_bank_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 16'h0000) |=> (ram_bank == $past(din[RAM_BANK_W-1:0])));

    // R7: a ROM bank store keeps only the low data bits
    p_rom_bank_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 16'h0001) |=> (rom_bank == $past(din[ROM_BANK_W-1:0])));

    // R9: RAM bank holds when no store targets it
    p_ram_bank_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == 16'h0000) |=> $stable(ram_bank));

    // R9: ROM bank holds when no store targets it
    p_rom_bank_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == 16'h0001) |=> $stable(rom_bank));

endmodule

// File: rtl/bank_addr_decode.sv
// Module: bank_addr_decode (top)
// Address decode and bank selection for an 8-bit CPU with a 16-bit bus.
// Produces active-low selects for low RAM, the I/O page, a banked high-RAM
// window and a banked ROM window, plus their upper physical address lines.
// Assumes one complete access per clock cycle. Selects are combinational
// from the current address and the registered banks.
module bank_addr_decode
    import bank_dec_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned RAM_BANK_W  = 8,
    parameter int unsigned HRAM_CHIP_W = 2,
    parameter int unsigned ROM_BANK_W  = 5,
    localparam int unsigned HRAM_LO_W  = RAM_BANK_W - HRAM_CHIP_W,
    localparam int unsigned HRAM_DEVS  = 1 << HRAM_CHIP_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [15:0]           cpu_addr,
    input  logic                  cpu_wr,
    input  logic [DATA_W-1:0]     cpu_din,
    output logic [HRAM_LO_W-1:0]  hram_addr_hi,
    output logic [HRAM_DEVS-1:0]  hram_cs_n,
    output logic [ROM_BANK_W-1:0] rom_addr_hi,
    output logic                  rom_cs_n,
    output logic                  io_cs_n,
    output logic                  lram_cs_n,
    output logic                  lram_we_n
);

    region_e               region;
    logic [RAM_BANK_W-1:0] ram_bank;
    logic [ROM_BANK_W-1:0] rom_bank;
    logic                  hram_en;

    region_decode u_region (
        .addr   (cpu_addr),
        .region (region)
    );

    bank_regs #(
        .DATA_W     (DATA_W),
        .RAM_BANK_W (RAM_BANK_W),
        .ROM_BANK_W (ROM_BANK_W)
    ) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (cpu_addr),
        .wr       (cpu_wr),
        .din      (cpu_din),
        .ram_bank (ram_bank),
        .rom_bank (rom_bank)
    );

    // Enable the high-RAM device decoder only inside its window
    assign hram_en = (region == RGN_HRAM);

    cs_decoder #(.SEL_W(HRAM_CHIP_W)) u_hram_cs (
        .en   (hram_en),
        .sel  (ram_bank[RAM_BANK_W-1 -: HRAM_CHIP_W]),
        .cs_n (hram_cs_n)
    );

    // Drive the single-device selects and the low-RAM write strobe
    always_comb begin
        lram_cs_n = (region != RGN_LOW);
        io_cs_n   = (region != RGN_IO);
        rom_cs_n  = (region != RGN_ROM);
        lram_we_n = !((region == RGN_LOW) && cpu_wr);
    end

    // Upper physical address lines come straight from the bank latches
    always_comb begin
        hram_addr_hi = ram_bank[HRAM_LO_W-1:0];
        rom_addr_hi  = rom_bank;
    end

    // R8: exactly one select is low in every cycle
    p_one_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~hram_cs_n, ~rom_cs_n, ~io_cs_n, ~lram_cs_n}) == 1);

    // R3: I/O select only inside page $9F
    p_io_page_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !io_cs_n |-> (cpu_addr[15:8] == 8'h9F));

    // R4: a high-RAM device is selected only inside $A000-$BFFF
    p_hram_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hram_cs_n != '1) |-> (cpu_addr[15:13] == 3'b101));

    // R5: ROM select only in the top 16 KB
    p_rom_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_cs_n |-> (cpu_addr[15:14] == 2'b11));

    // R10: low-RAM write strobe needs a write and the low-RAM select
    p_we_in_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !lram_we_n |-> (cpu_wr && !lram_cs_n));

endmodule

// File: tb/bank_addr_decode_test.sv
`timescale 1ns/1ps
module bank_addr_decode_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_din = 8'h00;
    logic [5:0]  hram_addr_hi;
    logic [3:0]  hram_cs_n;
    logic [4:0]  rom_addr_hi;
    logic        rom_cs_n, io_cs_n, lram_cs_n, lram_we_n;

    int unsigned vectors = 0;
    int unsigned fails   = 0;
    logic [7:0]  ram_m = 8'h00;   // bench model of the RAM bank
    logic [4:0]  rom_m = 5'h00;   // bench model of the ROM bank
    bit          done = 1'b0;

    bank_addr_decode uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_din(cpu_din), .hram_addr_hi(hram_addr_hi), .hram_cs_n(hram_cs_n),
        .rom_addr_hi(rom_addr_hi), .rom_cs_n(rom_cs_n), .io_cs_n(io_cs_n),
        .lram_cs_n(lram_cs_n), .lram_we_n(lram_we_n)
    );

    always #5 clk = ~clk;

    // Drive one access at the falling edge, check mid-cycle, update the model
    task automatic access(input logic [15:0] a, input logic w,
                          input logic [7:0] d, input string tag);
        logic [6:0] exp_cs;
        logic       exp_we_n;
        string      rq;
        @(negedge clk);
        cpu_addr = a; cpu_wr = w; cpu_din = d;
        #1;
        exp_cs   = 7'b1111111;            // {lram, io, rom, hram[3:0]}
        exp_we_n = 1'b1;
        if (a < 16'h9F00) begin
            exp_cs[6] = 1'b0; exp_we_n = !w; rq = "R2";
        end else if (a[15:8] == 8'h9F) begin
            exp_cs[5] = 1'b0; rq = "R3";
        end else if (a < 16'hC000) begin
            exp_cs[ram_m[7:6]] = 1'b0; rq = "R4";
        end else begin
            exp_cs[4] = 1'b0; rq = "R5";
        end
        vectors++;
        if ({lram_cs_n, io_cs_n, rom_cs_n, hram_cs_n} !== exp_cs ||
            lram_we_n !== exp_we_n ||
            (rq == "R4" && hram_addr_hi !== ram_m[5:0]) ||
            (rq == "R5" && rom_addr_hi !== rom_m)) begin
            fails++;
            $display("FAIL %s/%s addr=%h wr=%b: cs=%b we_n=%b hhi=%h rhi=%h exp cs=%b we_n=%b hhi=%h rhi=%h",
                     tag, rq, a, w, {lram_cs_n, io_cs_n, rom_cs_n, hram_cs_n},
                     lram_we_n, hram_addr_hi, rom_addr_hi, exp_cs, exp_we_n,
                     ram_m[5:0], rom_m);
        end
        if (w && a == 16'h0000) ram_m = d;
        if (w && a == 16'h0001) rom_m = d[4:0];
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: banks cleared by reset
        access(16'hA000, 1'b0, 8'h00, "R1");
        access(16'hC000, 1'b0, 8'h00, "R1");

        // R6: each top-bit pattern reaches its own device, effective next access
        for (int k = 0; k < 4; k++) begin
            access(16'h0000, 1'b1, 8'((k << 6) | (k * 13)), "R6");
            access(16'hA123, 1'b0, 8'h00, "R6");
        end

        // R7: upper data bits ignored
        access(16'h0001, 1'b1, 8'hFF, "R7");
        access(16'hFFFF, 1'b0, 8'h00, "R7");
        access(16'h0001, 1'b1, 8'hE3, "R7");
        access(16'hC000, 1'b0, 8'h00, "R7");

        // R9: reads of the bank locations and other writes leave banks alone
        access(16'h0000, 1'b0, 8'h55, "R9");
        access(16'h0001, 1'b0, 8'hAA, "R9");
        access(16'h0002, 1'b1, 8'h77, "R9");
        access(16'hA000, 1'b1, 8'h11, "R9");
        access(16'hBFFF, 1'b0, 8'h00, "R9");
        access(16'hDFFF, 1'b0, 8'h00, "R9");

        // R10: writes to I/O, high RAM and ROM give no low-RAM strobe
        access(16'h9F00, 1'b1, 8'h01, "R10");
        access(16'hB000, 1'b1, 8'h02, "R10");
        access(16'hE000, 1'b1, 8'h03, "R10");

        // R2..R5, R8: page boundary sweep, both ends of every page
        for (int p = 0; p < 256; p++) begin
            access(16'(p << 8), 1'b0, 8'h00, "R8");
            access(16'((p << 8) | 8'hFF), 1'b1, 8'h00, "R8");
        end

        // R2..R5: strided sweep of the map under several bank settings
        for (int k = 0; k < 8; k++) begin
            access(16'h0000, 1'b1, 8'($urandom), "R6");
            access(16'h0001, 1'b1, 8'($urandom), "R7");
            for (int a = k; a < 65536; a += 23)
                access(16'(a), 1'(a[0]), 8'h00, "R8");
        end

        // Mixed random traffic including bank stores
        for (int i = 0; i < 3000; i++) begin
            int unsigned r = $urandom % 4;
            logic [15:0] a = (r == 0) ? 16'($urandom % 2) : 16'($urandom);
            access(a, 1'($urandom), 8'($urandom), "R8");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #1500000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule